// File: doc/BRIEF.md
# Audio Key Scanner and Encoder

This block watches four push-button levels for an audio device and turns them into two kinds of output. While the device is attached to its host bus, the accepted key states are combined into a small bitmap that host-side request logic pulls through a valid/ready port. While the bus is absent, the same keys act directly: volume keys emit step pulses for the local volume control, the mute key emits a toggle pulse, and the bass-boost key is ignored. In bus mode the bass-boost key instead raises a toggle pulse for the local boost feature, and the volume and mute pulses stay quiet.

Every key passes through a two-stage synchronizer and a debounce filter that counts poll strobes, not clock cycles, so the scan rate is set by whoever drives the strobe. Held volume keys auto-repeat. A separate four-bit register drives indicator LEDs; it has no fixed meaning and changes only on a write.

The report port obeys the usual stream rules: once the report is raised, its code does not change until the consumer takes it with ready high at a clock edge. The one exception is a bus disconnect, which withdraws a pending report. A new report is offered only when the key bitmap differs from the last one delivered.

Top module: `akey_scanner`

## Requirements
- R1: During and straight after reset every output is low: no pulses, rpt_valid low, rpt_code zero, led_out zero.
- R2: A key level reaches the debounced state only at the 16th consecutive poll strobe that sees the new (synchronized) level; any strobe that sees the currently accepted level restarts that count.
- R3: The report code is the OR of the codes of all accepted-pressed keys: key 0 (volume up) is 1, key 1 (volume down) is 2, key 2 (mute) is 4, key 3 (bass boost) is 8; simultaneous presses are reported in one code.
- R4: With the bus connected, when the bitmap differs from the last delivered code, rpt_valid rises carrying a snapshot; rpt_valid and rpt_code then hold until a clock edge with rpt_ready high, after which the delivered code becomes the new reference.
- R5: While bus_on is low, rpt_valid is low from the next cycle on, even if a report was pending.
- R6: With the bus absent, each accepted press of key 0 or key 1 gives one vol_up or vol_dn pulse, and while the key stays held a further pulse follows every 32 poll strobes.
- R7: With the bus absent, each accepted press of key 2 gives exactly one mute_tgl pulse, with no repeat while held.
- R8: With the bus connected, vol_up, vol_dn and mute_tgl never pulse.
- R9: Each accepted press of key 3 gives one boost_tgl pulse only when the bus is connected; with the bus absent the key has no effect on any output.
- R10: A clock edge with led_wr_en high loads led_wr_data into led_out; without the enable led_out holds.
- R11: Every command pulse (vol_up, vol_dn, mute_tgl, boost_tgl) is one clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_raw | input | 4 | Raw key levels, 1 = pressed, bit k is key k |
| poll | input | 1 | One-cycle scan strobe |
| bus_on | input | 1 | High while the host bus is connected |
| rpt_ready | input | 1 | Report consumer ready |
| led_wr_en | input | 1 | LED register write enable |
| led_wr_data | input | 4 | LED register write data |
| rpt_valid | output | 1 | Report pending |
| rpt_code | output | 4 | Report key-code bitmap |
| vol_up | output | 1 | Volume-up step pulse |
| vol_dn | output | 1 | Volume-down step pulse |
| mute_tgl | output | 1 | Mute toggle pulse |
| boost_tgl | output | 1 | Bass-boost toggle pulse |
| led_out | output | 4 | LED drive outputs |

## Verification
The bench walks a key sequence that crosses the debounce limit one strobe short and exactly on it, so a filter that accepts at 15 or 17 strobes shows a missing or misplaced pulse. Bounces split around a release check that the count restarts; a filter that only pauses would accept early. Held volume keys are run across one and two repeat periods and across a mode switch, which catches an off-by-one repeat interval or a repeat leaking into bus mode. The report port is held off while the keys change underneath it and then released, so a design that lets the code drift before the handshake, drops the queued change, or keeps a report raised after a disconnect is caught; the bass-boost key is pressed in both modes.

// File: rtl/akey_pkg.sv
package akey_pkg;
  localparam int unsigned KEY_COUNT = 4;

  typedef enum logic [1:0] {
    KEY_VOL_UP = 2'd0,
    KEY_VOL_DN = 2'd1,
    KEY_MUTE   = 2'd2,
    KEY_BOOST  = 2'd3
  } key_idx_e;

  // Code bit of a key inside the report bitmap.
  function automatic logic [KEY_COUNT-1:0] key_code(input key_idx_e k);
    return KEY_COUNT'(1) << k;
  endfunction
endpackage

// File: rtl/akey_debounce.sv
module akey_debounce #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_POLLS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic poll,
  output logic level
);
  localparam int unsigned CW = (DEB_POLLS > 1) ? $clog2(DEB_POLLS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_POLLS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sampled;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
  end
  assign sampled = sync_q[SYNC_STAGES-1];

  // Count strobes that disagree with the accepted level; agreement restarts.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      level <= 1'b0;
    end else if (poll) begin
      if (sampled == level) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        level <= sampled;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: the accepted level only moves on a strobe edge
  assert_change_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> $past(poll));
endmodule

// File: rtl/akey_event.sv
module akey_event #(
  parameter bit          REP_EN    = 1'b1,
  parameter int unsigned REP_POLLS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic poll,
  output logic fire
);
  localparam int unsigned RW = (REP_POLLS > 1) ? $clog2(REP_POLLS) : 1;
  localparam logic [RW-1:0] REP_LAST = RW'(REP_POLLS - 1);

  logic          level_q;
  logic [RW-1:0] rep_q;
  logic          press;
  logic          rep_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  // Strobes counted since the press or the last repeat.
  always_ff @(posedge clk) begin
    if (!rst_n || !level) rep_q <= '0;
    else if (poll)        rep_q <= (rep_q == REP_LAST) ? '0 : rep_q + 1'b1;
  end

  assign press   = level & ~level_q;
  assign rep_hit = REP_EN && level && poll && (rep_q == REP_LAST);
  assign fire    = press | rep_hit;
endmodule

// File: rtl/akey_report.sv
module akey_report #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_on,
  input  logic [W-1:0] bitmap,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] code
);
  logic [W-1:0] sent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      code   <= '0;
      sent_q <= '0;
    end else if (!bus_on) begin
      valid <= 1'b0;
    end else if (valid) begin
      if (ready) begin
        valid  <= 1'b0;
        sent_q <= code;
      end
    end else if (bitmap != sent_q) begin
      code  <= bitmap;
      valid <= 1'b1;
    end
  end

  // R4: a pending report keeps its code until taken
  assert_hold_until_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && !$past(ready)) |-> (code == $past(code)));

  // R5: a disconnect withdraws the report
  assert_drop_on_disconnect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_on |=> !valid);
endmodule

// File: rtl/akey_scanner.sv
module akey_scanner
  import akey_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_POLLS   = 16,
  parameter int unsigned REP_POLLS   = 32,
  parameter int unsigned NLED        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KEY_COUNT-1:0] key_raw,
  input  logic                 poll,
  input  logic                 bus_on,
  input  logic                 rpt_ready,
  input  logic                 led_wr_en,
  input  logic [NLED-1:0]      led_wr_data,
  output logic                 rpt_valid,
  output logic [KEY_COUNT-1:0] rpt_code,
  output logic                 vol_up,
  output logic                 vol_dn,
  output logic                 mute_tgl,
  output logic                 boost_tgl,
  output logic [NLED-1:0]      led_out
);
  logic [KEY_COUNT-1:0] level;
  logic [KEY_COUNT-1:0] fire;
  logic [KEY_COUNT-1:0] bitmap;

  for (genvar k = 0; k < KEY_COUNT; k++) begin : g_key
    localparam bit IS_VOL = (k == int'(KEY_VOL_UP)) || (k == int'(KEY_VOL_DN));

    akey_debounce #(
      .SYNC_STAGES(SYNC_STAGES),
      .DEB_POLLS  (DEB_POLLS)
    ) u_deb (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (key_raw[k]),
      .poll (poll),
      .level(level[k])
    );

    akey_event #(
      .REP_EN   (IS_VOL),
      .REP_POLLS(REP_POLLS)
    ) u_evt (
      .clk  (clk),
      .rst_n(rst_n),
      .level(level[k]),
      .poll (poll),
      .fire (fire[k])
    );
  end

  always_comb begin
    bitmap = '0;
    for (int k = 0; k < KEY_COUNT; k++) begin
      if (level[k]) bitmap = bitmap | key_code(key_idx_e'(k));
    end
  end

  akey_report #(.W(KEY_COUNT)) u_rpt (
    .clk   (clk),
    .rst_n (rst_n),
    .bus_on(bus_on),
    .bitmap(bitmap),
    .ready (rpt_ready),
    .valid (rpt_valid),
    .code  (rpt_code)
  );

  // Local commands: volume and mute stand-alone only, boost bus mode only.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol_up    <= 1'b0;
      vol_dn    <= 1'b0;
      mute_tgl  <= 1'b0;
      boost_tgl <= 1'b0;
    end else begin
      vol_up    <= !bus_on && fire[KEY_VOL_UP];
      vol_dn    <= !bus_on && fire[KEY_VOL_DN];
      mute_tgl  <= !bus_on && fire[KEY_MUTE];
      boost_tgl <=  bus_on && fire[KEY_BOOST];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         led_out <= '0;
    else if (led_wr_en) led_out <= led_wr_data;
  end

  // R8: no local volume or mute command while connected
  assert_quiet_on_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_up || vol_dn || mute_tgl) |-> !$past(bus_on));

  // R9: boost toggle only comes out in bus mode
  assert_boost_bus_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    boost_tgl |-> $past(bus_on));

  // R11: command pulses last one cycle
  assert_pulse_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_up || vol_dn || mute_tgl || boost_tgl) |=> !(vol_up || vol_dn || mute_tgl || boost_tgl));

  // R10: a write lands on the LEDs
  assert_led_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    led_wr_en |=> (led_out == $past(led_wr_data)));
endmodule

// File: tb/tb_akey_scanner.sv
module tb_akey_scanner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] key_raw = '0;
  logic       poll = 1'b0;
  logic       bus_on = 1'b0;
  logic       rpt_ready = 1'b1;
  logic       led_wr_en = 1'b0;
  logic [3:0] led_wr_data = '0;
  logic       rpt_valid;
  logic [3:0] rpt_code;
  logic       vol_up, vol_dn, mute_tgl, boost_tgl;
  logic [3:0] led_out;

  int total = 0;
  int bad = 0;
  int n_up = 0, n_dn = 0, n_mute = 0, n_boost = 0, n_wide = 0;
  logic [3:0] last_code = '0;
  logic       prev_any = 1'b0;

  always #10 clk = ~clk;

  akey_scanner dut (
    .clk(clk), .rst_n(rst_n), .key_raw(key_raw), .poll(poll), .bus_on(bus_on),
    .rpt_ready(rpt_ready), .led_wr_en(led_wr_en), .led_wr_data(led_wr_data),
    .rpt_valid(rpt_valid), .rpt_code(rpt_code), .vol_up(vol_up), .vol_dn(vol_dn),
    .mute_tgl(mute_tgl), .boost_tgl(boost_tgl), .led_out(led_out)
  );

  // Monitor away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      n_up    += int'(vol_up);
      n_dn    += int'(vol_dn);
      n_mute  += int'(mute_tgl);
      n_boost += int'(boost_tgl);
      if (prev_any && (vol_up || vol_dn || mute_tgl || boost_tgl)) n_wide++;
      prev_any = vol_up || vol_dn || mute_tgl || boost_tgl;
      if (rpt_valid && rpt_ready) last_code = rpt_code;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_polls(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) poll = 1'b1;
      @(negedge clk) poll = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic       bus;
    logic [3:0] keys;
    logic [7:0] polls;
    logic [1:0] up;
    logic [1:0] dn;
    logic [1:0] mute;
    logic [1:0] boost;
    logic [3:0] code;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 4'b0001, 8'd15, 2'd0, 2'd0, 2'd0, 2'd0, 4'h0},
    '{1'b0, 4'b0001, 8'd1,  2'd1, 2'd0, 2'd0, 2'd0, 4'h0},
    '{1'b0, 4'b0001, 8'd31, 2'd0, 2'd0, 2'd0, 2'd0, 4'h0},
    '{1'b0, 4'b0001, 8'd1,  2'd1, 2'd0, 2'd0, 2'd0, 4'h0},
    '{1'b0, 4'b0001, 8'd32, 2'd1, 2'd0, 2'd0, 2'd0, 4'h0},
    '{1'b0, 4'b0000, 8'd16, 2'd0, 2'd0, 2'd0, 2'd0, 4'h0},
    '{1'b0, 4'b1000, 8'd16, 2'd0, 2'd0, 2'd0, 2'd0, 4'h0},
    '{1'b0, 4'b1100, 8'd16, 2'd0, 2'd0, 2'd1, 2'd0, 4'h0},
    '{1'b0, 4'b0000, 8'd16, 2'd0, 2'd0, 2'd0, 2'd0, 4'h0},
    '{1'b1, 4'b1000, 8'd16, 2'd0, 2'd0, 2'd0, 2'd1, 4'h8},
    '{1'b1, 4'b1001, 8'd16, 2'd0, 2'd0, 2'd0, 2'd0, 4'h9},
    '{1'b1, 4'b0110, 8'd16, 2'd0, 2'd0, 2'd0, 2'd0, 4'h6},
    '{1'b1, 4'b0000, 8'd16, 2'd0, 2'd0, 2'd0, 2'd0, 4'h0},
    '{1'b0, 4'b0010, 8'd16, 2'd0, 2'd1, 2'd0, 2'd0, 4'h0},
    '{1'b0, 4'b0010, 8'd64, 2'd0, 2'd2, 2'd0, 2'd0, 4'h0},
    '{1'b1, 4'b0010, 8'd40, 2'd0, 2'd0, 2'd0, 2'd0, 4'h2},
    '{1'b0, 4'b0000, 8'd16, 2'd0, 2'd0, 2'd0, 2'd0, 4'h2},
    '{1'b0, 4'b0001, 8'd10, 2'd0, 2'd0, 2'd0, 2'd0, 4'h2},
    '{1'b0, 4'b0000, 8'd3,  2'd0, 2'd0, 2'd0, 2'd0, 4'h2},
    '{1'b0, 4'b0001, 8'd10, 2'd0, 2'd0, 2'd0, 2'd0, 4'h2},
    '{1'b0, 4'b0001, 8'd6,  2'd1, 2'd0, 2'd0, 2'd0, 4'h2}
  };

  initial begin
    // R1: reset state
    settle(3);
    chk({rpt_valid, vol_up, vol_dn, mute_tgl, boost_tgl} == 5'b0, "R1 pulses/valid in reset", 0, 0);
    @(negedge clk) rst_n = 1'b1;
    settle(2);
    chk(rpt_code == 4'h0 && !rpt_valid, "R1 report after reset", int'(rpt_code), 0);
    chk(led_out == 4'h0, "R1 leds after reset", int'(led_out), 0);

    for (int i = 0; i < NV; i++) begin
      int b_up, b_dn, b_mute, b_boost;
      @(negedge clk);
      bus_on  = TBL[i].bus;
      key_raw = TBL[i].keys;
      settle(3);
      b_up = n_up; b_dn = n_dn; b_mute = n_mute; b_boost = n_boost;
      do_polls(int'(TBL[i].polls));
      settle(4);
      chk(n_up - b_up == int'(TBL[i].up), TBL[i].bus ? "R8 vol_up" : "R2 R6 vol_up",
          n_up - b_up, int'(TBL[i].up));
      chk(n_dn - b_dn == int'(TBL[i].dn), TBL[i].bus ? "R8 vol_dn" : "R6 vol_dn",
          n_dn - b_dn, int'(TBL[i].dn));
      chk(n_mute - b_mute == int'(TBL[i].mute), "R7 mute_tgl", n_mute - b_mute, int'(TBL[i].mute));
      chk(n_boost - b_boost == int'(TBL[i].boost), "R9 boost_tgl", n_boost - b_boost, int'(TBL[i].boost));
      chk(last_code == TBL[i].code, "R3 report code", int'(last_code), int'(TBL[i].code));
    end

    // R4: back-pressure. Key 0 held, last delivered 2 -> report 1 pending.
    rpt_ready = 1'b0;
    bus_on = 1'b1;
    settle(3);
    chk(rpt_valid && rpt_code == 4'h1, "R4 report raised", int'(rpt_code), 1);
    key_raw = 4'b0011;
    settle(3);
    do_polls(16);
    settle(3);
    chk(rpt_valid && rpt_code == 4'h1, "R4 code held without ready", int'(rpt_code), 1);
    rpt_ready = 1'b1;
    settle(6);
    chk(last_code == 4'h3, "R4 queued change delivered", int'(last_code), 3);
    chk(!rpt_valid, "R4 idle after delivery", int'(rpt_valid), 0);

    // R5: pending report withdrawn on disconnect
    rpt_ready = 1'b0;
    key_raw = 4'b0000;
    settle(3);
    do_polls(16);
    settle(3);
    chk(rpt_valid && rpt_code == 4'h0, "R5 pending before disconnect", int'(rpt_valid), 1);
    bus_on = 1'b0;
    settle(2);
    chk(!rpt_valid, "R5 withdrawn on disconnect", int'(rpt_valid), 0);

    // R10: LED register
    led_wr_data = 4'b1010; led_wr_en = 1'b1;
    @(negedge clk) led_wr_en = 1'b0;
    chk(led_out == 4'b1010, "R10 led write", int'(led_out), 10);
    led_wr_data = 4'b0101;
    settle(4);
    chk(led_out == 4'b1010, "R10 led hold without enable", int'(led_out), 10);
    led_wr_en = 1'b1;
    @(negedge clk) led_wr_en = 1'b0;
    chk(led_out == 4'b0101, "R10 led rewrite", int'(led_out), 5);

    chk(n_wide == 0, "R11 pulse width", n_wide, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule